// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on an idle-high line. A one-cycle oversampling strobe (`tick`) arrives at sixteen times the bit rate. The receiver waits for a falling edge and confirms it half a bit later, which rejects short glitches. It then samples each following bit at its centre. Data arrives least significant bit first. An optional parity bit and one or two stop bits follow the data. The data length (full or one bit shorter), parity enable, parity sense and stop-bit count come from static configuration pins.

Each completed frame is judged for overrun, parity and framing. The result goes into a small status state: a data-full flag and three sticky error flags. The received word is offered on a valid/ready output. `rd_valid` is the data-full flag. A transfer takes place in any cycle where `rd_valid` and `rd_ready` are both 1, and that transfer clears the flag. The consumer may hold `rd_ready` low for as long as it likes. If a further frame completes while `rd_valid` is still 1, that frame is lost and flagged as an overrun.

While any error flag is set, the receiver starts no new frame. Software clears the error flags with a write-one-to-clear strobe. Two interrupt outputs, one for data and one for errors, share a single enable.

Top module: `async_rx`

## Requirements
- R1: After reset, `rd_valid`, all three error flags, both interrupts and `rd_data` are 0.
- R2: A low level on the line is taken as a start bit only if it is still low 8 ticks after the fall. A low pulse shorter than that starts no frame and leaves the outputs unchanged.
- R3: Data bits are assembled least significant bit first. With `cfg_short`=0 the word is 8 bits wide. With `cfg_short`=1 it is 7 bits, placed in `rd_data[6:0]`, and `rd_data[7]` reads 0.
- R4: A frame that has no error and completes while `rd_valid`=0 is copied to `rd_data`, and `rd_valid` goes to 1.
- R5: A cycle with `rd_valid`=1 and `rd_ready`=1 is a transfer; in the next cycle `rd_valid` is 0. While `rd_valid`=1, `rd_data` does not change.
- R6: With `cfg_par_en`=1, the number of 1s in the data bits plus the parity bit must be even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. A mismatch sets `err_parity`, copies the word to `rd_data` and leaves `rd_valid` at 0. With `cfg_par_en`=0 the frame has no parity bit and `err_parity` is never set.
- R7: A first stop bit that reads 0 sets `err_frame`, copies the word to `rd_data` and leaves `rd_valid` at 0. With `cfg_two_stop`=1 the second stop bit is not checked.
- R8: A frame that completes while `rd_valid`=1 sets only `err_overrun`. Its own parity and stop results are ignored, `rd_data` keeps the earlier word and `rd_valid` stays 1.
- R9: While any error flag is 1, no new frame is received: `rd_data`, `rd_valid` and the flags are untouched by line activity.
- R10: `err_clr` is write-one-to-clear, with bit 0 for `err_overrun`, bit 1 for `err_frame` and bit 2 for `err_parity`. Each bit clears only its own flag. If a flag is set and cleared in the same cycle, it ends up set.
- R11: `irq_rx` is 1 when `irq_en` and `rd_valid` are both 1. `irq_err` is 1 when `irq_en` is 1 and any error flag is 1. When `irq_en`=0, both are 0.
- R12: All bit timing counts `tick` strobes only, so frames are received correctly at any spacing of the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| rx_line | input | 1 | Serial input, idle high |
| cfg_short | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Two stop bits in the frame |
| irq_en | input | 1 | Enable for both interrupts |
| rd_data | output | 8 | Receive data register |
| rd_valid | output | 1 | Data-full flag / stream valid |
| rd_ready | input | 1 | Consumer accepts the word |
| err_clr | input | 3 | Write-one-to-clear strobes for the error flags |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
An error flag can be set by a completing frame in the same cycle that software tries to clear it. The bench provokes this by holding the matching `err_clr` bit at 1 through a whole frame with bad parity. It then counts the cycles in which `err_parity` reads 1: exactly one is expected, because the set wins over the clear in that cycle and the held clear removes the flag in the next. A second same-cycle case is a frame completing while `rd_valid` is held by a stalled consumer. It is judged from the outputs: the overrun flag rises, while the earlier word and `rd_valid` stay as they were.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP1, RX_STOP2
  } rx_state_e;

  typedef struct packed {
    logic par_bad;
    logic stop_bad;
  } frame_chk_t;

  localparam int unsigned ERR_OVR = 0;
  localparam int unsigned ERR_FRM = 1;
  localparam int unsigned ERR_PAR = 2;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/async_rx_framer.sv
module async_rx_framer
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              hold,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output frame_chk_t        chk
);
  localparam int unsigned CNT_W = $clog2(2 * OSR);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID   = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] TAIL  = CNT_W'(OSR + OSR / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_F = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_S = IDX_W'(DATA_W - 2);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              stop_bad;
  logic [IDX_W-1:0]  idx_last;
  logic              at_centre;

  assign idx_last  = cfg_short ? IDX_S : IDX_F;
  assign at_centre = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      stop_bad <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        cnt <= cnt + 1'b1;
        unique case (state)
          RX_IDLE: begin
            cnt <= '0;
            if (!hold && !rx_s) state <= RX_START;
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              state <= rx_s ? RX_IDLE : RX_DATA;
            end
          end
          RX_DATA: begin
            if (at_centre) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[DATA_W-1:1]};
              if (idx == idx_last) state <= cfg_par_en ? RX_PAR : RX_STOP1;
              else                 idx   <= idx + 1'b1;
            end
          end
          RX_PAR: begin
            if (at_centre) begin
              cnt     <= '0;
              par_bit <= rx_s;
              state   <= RX_STOP1;
            end
          end
          RX_STOP1: begin
            if (at_centre) begin
              cnt      <= '0;
              stop_bad <= ~rx_s;
              done     <= 1'b1;
              state    <= cfg_two_stop ? RX_STOP2 : RX_IDLE;
            end
          end
          RX_STOP2: begin
            if (cnt == TAIL) begin
              cnt   <= '0;
              state <= RX_IDLE;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign word         = cfg_short ? {1'b0, shreg[DATA_W-1:1]} : shreg;
  assign chk.par_bad  = cfg_par_en && ((^word ^ par_bit) != cfg_par_odd);
  assign chk.stop_bad = stop_bad;
endmodule

// File: rtl/async_rx_status.sv
module async_rx_status
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  frame_chk_t        chk,
  input  logic              rd_ready,
  input  logic [2:0]        err_clr,
  input  logic              irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [2:0]        errs,
  output logic              hold,
  output logic              irq_rx,
  output logic              irq_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      errs     <= '0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      errs <= errs & ~err_clr;
      if (done) begin
        if (rd_valid) begin
          errs[ERR_OVR] <= 1'b1;
        end else begin
          rd_data <= word;
          if (chk.par_bad)  errs[ERR_PAR] <= 1'b1;
          if (chk.stop_bad) errs[ERR_FRM] <= 1'b1;
          if (!chk.par_bad && !chk.stop_bad) rd_valid <= 1'b1;
        end
      end
    end
  end

  assign hold    = |errs;
  assign irq_rx  = irq_en & rd_valid;
  assign irq_err = irq_en & (|errs);
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_line,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic [2:0]        err_clr,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_parity,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              rx_s;
  logic              hold;
  logic              done;
  logic [DATA_W-1:0] word;
  frame_chk_t        chk;
  logic [2:0]        errs;

  async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_line), .d_out(rx_s)
  );

  async_rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .hold(hold),
    .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .done(done), .word(word), .chk(chk)
  );

  async_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .done(done), .word(word), .chk(chk),
    .rd_ready(rd_ready), .err_clr(err_clr), .irq_en(irq_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .errs(errs), .hold(hold),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  assign err_overrun = errs[ERR_OVR];
  assign err_frame   = errs[ERR_FRM];
  assign err_parity  = errs[ERR_PAR];
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_par_en,
  input logic              irq_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [2:0]        err_clr,
  input logic              err_overrun,
  input logic              err_frame,
  input logic              err_parity,
  input logic              irq_rx,
  input logic              irq_err
);
  // R5: a transfer empties the data register flag
  a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_valid);

  // R5 / R8: a held word is never overwritten
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> $stable(rd_data));

  // R9: no fresh word while reception is frozen
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun || err_frame || err_parity) |=> !$rose(rd_valid));

  // R10: parity flag persists until its clear bit
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity && !err_clr[2] |=> err_parity);

  // R11: the enable masks both interrupts
  a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_rx && !irq_err);

  // R6: parity flag only rises with parity enabled
  a_r6_par_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> $past(cfg_par_en));
endmodule

bind async_rx async_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .irq_en(irq_en),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .err_clr(err_clr), .err_overrun(err_overrun), .err_frame(err_frame),
  .err_parity(err_parity), .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/async_rx_bench.sv
module async_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       cfg_short = 1'b0, cfg_par_en = 1'b1, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       irq_en = 1'b1;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [2:0] err_clr = 3'b000;
  logic       err_overrun, err_frame, err_parity, irq_rx, irq_err;

  int n_checks = 0;
  int n_fail = 0;
  int div = 1;
  int tcnt = 0;
  int par_hi = 0;
  bit count_par = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  async_rx u_async_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
    .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .irq_en(irq_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .err_clr(err_clr),
    .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  always @(negedge clk) begin
    if (tcnt >= div - 1) begin tick <= 1'b1; tcnt <= 0; end
    else begin tick <= 1'b0; tcnt <= tcnt + 1; end
    if (count_par && err_parity) par_hi <= par_hi + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    rx_line = b;
    repeat (16 * div) @(negedge clk);
  endtask

  function automatic logic par_of(input logic [7:0] d, input int n, input logic odd);
    logic p = odd;
    for (int i = 0; i < n; i++) p ^= d[i];
    return p;
  endfunction

  task automatic send(input logic [7:0] d, input logic pbit, input logic s1, input logic s2);
    int n = cfg_short ? 7 : 8;
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(d[i]);
    if (cfg_par_en) bit_out(pbit);
    bit_out(s1);
    if (cfg_two_stop) bit_out(s2);
    bit_out(1'b1);
    bit_out(1'b1);
  endtask

  task automatic send_ok(input logic [7:0] d);
    send(d, par_of(d, cfg_short ? 7 : 8, cfg_par_odd), 1'b1, 1'b1);
  endtask

  task automatic take();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic clear_all();
    err_clr = 3'b111;
    @(negedge clk);
    err_clr = 3'b000;
    @(negedge clk);
  endtask

  function automatic int errv();
    return {err_parity, err_frame, err_overrun};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!rd_valid && errv() == 0 && !irq_rx && !irq_err && rd_data == 0,
          "R1 reset", {rd_valid, errv(), irq_rx, irq_err, rd_data}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5 R6 R11: 8 bits, even parity, every value
    for (int v = 0; v < 256; v++) begin
      send_ok(8'(v));
      check(rd_valid && rd_data == 8'(v) && errv() == 0 && irq_rx,
            "R4 8-bit even", rd_data, v);
      take();
      check(!rd_valid && !irq_rx, "R5 handshake clears", rd_valid, 0);
    end

    // R3 R6 R7: 7 bits, odd parity, two stop bits, every value
    cfg_short = 1'b1; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
    for (int v = 0; v < 128; v++) begin
      send_ok(8'(v) | 8'h80);
      check(rd_valid && rd_data == 8'(v) && errv() == 0,
            "R3 7-bit odd", rd_data, v);
      take();
    end

    // R7: second stop bit low is not checked
    send(8'h2B, par_of(8'h2B, 7, 1'b1), 1'b1, 1'b0);
    check(rd_valid && rd_data == 8'h2B && !err_frame, "R7 stop2 unchecked", errv(), 0);
    take();

    // R6: parity error copies word, no valid, error irq
    cfg_short = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
    irq_en = 1'b0;
    send(8'h96, ~par_of(8'h96, 8, 1'b0), 1'b1, 1'b1);
    check(err_parity && !err_frame && !err_overrun && !rd_valid && rd_data == 8'h96,
          "R6 parity error", {errv(), rd_data}, {3'b100, 8'h96});
    check(!irq_err, "R11 irq masked", irq_err, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq_err && !irq_rx, "R11 error irq", irq_err, 1);

    // R9: frozen while flagged
    send_ok(8'hA5);
    check(rd_data == 8'h96 && !rd_valid && errv() == 3'b100, "R9 frozen",
          rd_data, 8'h96);
    clear_all();
    check(errv() == 0 && !irq_err, "R10 clear all", errv(), 0);
    send_ok(8'h3C);
    check(rd_valid && rd_data == 8'h3C, "R9 resumes", rd_data, 8'h3C);
    take();

    // R7 and R10: framing and parity together, selective clear
    send(8'h0F, ~par_of(8'h0F, 8, 1'b0), 1'b0, 1'b1);
    check(err_frame && err_parity && !rd_valid && rd_data == 8'h0F,
          "R7 framing error", errv(), 3'b110);
    err_clr = 3'b010;
    @(negedge clk);
    err_clr = 3'b000;
    @(negedge clk);
    check(errv() == 3'b100, "R10 selective clear", errv(), 3'b100);
    clear_all();

    // R8: overrun keeps old word; bad stop of the lost frame is ignored
    send_ok(8'h11);
    send(8'h22, par_of(8'h22, 8, 1'b0), 1'b0, 1'b1);
    check(errv() == 3'b001 && rd_valid && rd_data == 8'h11 && irq_rx && irq_err,
          "R8 overrun", {errv(), rd_data}, {3'b001, 8'h11});
    take();
    check(!rd_valid, "R8 take after overrun", rd_valid, 0);
    clear_all();

    // R6: parity disabled, no parity slot
    cfg_par_en = 1'b0;
    send(8'hE7, 1'b0, 1'b1, 1'b1);
    check(rd_valid && rd_data == 8'hE7 && !err_parity, "R6 parity off", rd_data, 8'hE7);
    take();

    // R2: glitch rejected, then clean frame still aligned
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (48) @(negedge clk);
    check(!rd_valid && errv() == 0 && rd_data == 8'hE7, "R2 glitch ignored",
          {rd_valid, errv()}, 0);
    send_ok(8'h81);
    check(rd_valid && rd_data == 8'h81 && errv() == 0, "R2 after glitch", rd_data, 8'h81);
    take();

    // R12: sparse ticks
    div = 3;
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    send_ok(8'h5A);
    check(rd_valid && rd_data == 8'h5A && errv() == 0, "R12 sparse tick", rd_data, 8'h5A);
    take();
    div = 1;
    repeat (8) @(negedge clk);

    // R10: set and clear in the same cycle, set wins
    err_clr = 3'b100;
    count_par = 1'b1;
    send(8'h44, ~par_of(8'h44, 8, 1'b1), 1'b1, 1'b1);
    count_par = 1'b0;
    err_clr = 3'b000;
    check(par_hi == 1, "R10 set wins once", par_hi, 1);
    check(!rd_valid && rd_data == 8'h44 && errv() == 0, "R10 after held clear",
          {rd_valid, errv()}, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule